// File: doc/BRIEF.md
# Luma Conditioning and 2x Interpolation Path

This block is the luminance leg of a composite video encoder. It runs on the 27 MHz core clock. Luma samples arrive at half that rate, qualified by a strobe `y_valid` that is high on every other cycle. Each strobed sample is scaled by a programmable unsigned gain. A signed black-level offset is then added, and the sum is clamped to a 10-bit code. While a sync tip or a blanking interval is in progress, the video sample is replaced by a programmable sync level or blanking level.

The resulting stream of 10-bit codes feeds a fixed halfband interpolator that doubles the sample rate:
- On one output phase the filter passes a stored sample through unchanged.
- On the other phase it produces a symmetric four-point mid-value.

Sync and blanking codes travel through the same filter as video, so their edges leave the block with soft transitions. Every output is clamped to the range 0 to 1023.

Top module: `luma_interp_path`

## Requirements
- R1: While `rst` is high, and after its release until samples have propagated, `luma_out` is 0.
- R2: For a strobed sample with both control flags low, the conditioned code is clamp(floor(y_in * gain / 32) + offset). Here `gain` is unsigned with 7 fraction bits (128 = unity), so y_in is also scaled onto the 10-bit range, and `offset` is two's complement.
- R3: Every conditioned code and every filter output is clamped to 0..1023 and never wraps.
- R4: When `sync_active` is high at a strobe, the conditioned code equals `sync_level`, whatever the state of `blank_active`.
- R5: When `blank_active` is high and `sync_active` is low at a strobe, the conditioned code equals `blank_level`.
- R6: With strobes on alternate cycles, a conditioned code x[n] appears unchanged on `luma_out` at the sixth rising edge after the edge at which its input was strobed.
- R7: At the edge after x[n] is output, `luma_out` takes clamp((9*(x[n]+x[n+1]) - x[n-1] - x[n+2] + 8) >> 4), where >> is an arithmetic shift. While no new sample arrives, this value is held.
- R8: `y_in`, `sync_active` and `blank_active` are ignored on cycles where `y_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz core clock |
| rst | input | 1 | Synchronous active-high reset |
| y_valid | input | 1 | Input sample strobe, high every other cycle |
| y_in | input | 8 | Luma input sample |
| gain | input | 8 | Unsigned gain, 1.7 fixed point |
| offset | input | 10 | Signed black-level offset in output codes |
| sync_active | input | 1 | Replace sample by sync tip level |
| blank_active | input | 1 | Replace sample by blanking level |
| sync_level | input | 10 | Sync tip code |
| blank_level | input | 10 | Blanking code |
| luma_out | output | 10 | Interpolated luma at the full clock rate |

## Verification
A wrong conditioned code shows up as a wrong even-phase output exactly six cycles after its strobe. It also corrupts the odd-phase outputs over the following eight cycles. A fault in the tap shift order or in the phase flag makes the steady alternation of pass-through and mid-value outputs differ from the reference. Such faults are visible as soon as neighbouring samples differ, and the bench's impulse and step patterns make neighbours differ. A dropped clamp shows up as a wrapped code within two cycles of a full-scale step.

// File: rtl/luma_pkg.sv
package luma_pkg;

    localparam int LUMA_W   = 10;
    localparam int LUMA_MAX = (1 << LUMA_W) - 1;
    localparam int ACC_W    = 20;

    // halfband interpolator: 4 stored codes, centre tap passes through
    localparam int HB_TAPS   = 4;
    localparam int HB_CENTER = HB_TAPS / 2;
    localparam int HB_NEAR   = 9;
    localparam int HB_FAR    = 1;
    localparam int HB_SHIFT  = 4;

    typedef enum logic [1:0] {
        SRC_VIDEO = 2'd0,
        SRC_BLANK = 2'd1,
        SRC_SYNC  = 2'd2
    } luma_src_e;

    typedef struct packed {
        logic              vld;
        logic [LUMA_W-1:0] lvl;
    } luma_smp_t;

    function automatic logic [LUMA_W-1:0] clamp_u(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi;
        hi = ACC_W'(LUMA_MAX);
        if (v < 0)
            return '0;
        else if (v > hi)
            return LUMA_W'(LUMA_MAX);
        else
            return v[LUMA_W-1:0];
    endfunction

    // mid-point between b and c, with outer neighbours a and d
    function automatic logic [LUMA_W-1:0] hb_mid(input logic [LUMA_W-1:0] a,
                                                 input logic [LUMA_W-1:0] b,
                                                 input logic [LUMA_W-1:0] c,
                                                 input logic [LUMA_W-1:0] d);
        logic signed [ACC_W-1:0] sa, sb, sc, sd, acc;
        sa  = ACC_W'(a);
        sb  = ACC_W'(b);
        sc  = ACC_W'(c);
        sd  = ACC_W'(d);
        acc = ACC_W'(HB_NEAR) * (sb + sc) - ACC_W'(HB_FAR) * (sa + sd)
              + ACC_W'(1 << (HB_SHIFT - 1));
        return clamp_u(acc >>> HB_SHIFT);
    endfunction

endpackage

// File: rtl/luma_condition.sv
module luma_condition
    import luma_pkg::*;
#(
    parameter int Y_W    = 8,
    parameter int G_W    = 8,
    parameter int G_FRAC = 7,
    parameter int OFS_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    y_valid,
    input  logic [Y_W-1:0]          y_in,
    input  logic [G_W-1:0]          gain,
    input  logic signed [OFS_W-1:0] offset,
    input  logic                    sync_active,
    input  logic                    blank_active,
    input  logic [LUMA_W-1:0]       sync_level,
    input  logic [LUMA_W-1:0]       blank_level,
    output luma_smp_t               smp
);
    localparam int PROD_W = Y_W + G_W;
    localparam int SHIFT  = G_FRAC - (LUMA_W - Y_W);

    logic [PROD_W-1:0]       prod;
    logic [PROD_W-1:0]       scaled;
    logic signed [ACC_W-1:0] biased;
    luma_src_e               src;
    logic [LUMA_W-1:0]       lvl_next;

    always_comb begin
        prod   = PROD_W'(y_in) * PROD_W'(gain);
        scaled = prod >> SHIFT;
        biased = $signed(ACC_W'(scaled)) + ACC_W'(offset);

        if (sync_active)
            src = SRC_SYNC;
        else if (blank_active)
            src = SRC_BLANK;
        else
            src = SRC_VIDEO;

        unique case (src)
            SRC_SYNC:  lvl_next = sync_level;
            SRC_BLANK: lvl_next = blank_level;
            default:   lvl_next = clamp_u(biased);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else begin
            smp.vld <= y_valid;
            if (y_valid)
                smp.lvl <= lvl_next;
        end
    end

endmodule

// File: rtl/luma_halfband.sv
module luma_halfband
    import luma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  luma_smp_t         smp,
    output logic              hb_even,
    output logic [LUMA_W-1:0] hb_center,
    output logic [LUMA_W-1:0] luma_out
);
    logic [LUMA_W-1:0] taps [HB_TAPS];

    for (genvar i = 0; i < HB_TAPS; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst)
                taps[i] <= '0;
            else if (smp.vld)
                taps[i] <= (i == 0) ? smp.lvl : taps[(i == 0) ? 0 : i - 1];
        end
    end

    assign hb_center = taps[HB_CENTER];

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_even  <= 1'b0;
            luma_out <= '0;
        end else begin
            hb_even  <= smp.vld;
            luma_out <= hb_even ? taps[HB_CENTER]
                                : hb_mid(taps[0], taps[1], taps[2], taps[3]);
        end
    end

endmodule

// File: rtl/luma_interp_path.sv
module luma_interp_path
    import luma_pkg::*;
#(
    parameter int Y_W    = 8,
    parameter int G_W    = 8,
    parameter int G_FRAC = 7,
    parameter int OFS_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    y_valid,
    input  logic [Y_W-1:0]          y_in,
    input  logic [G_W-1:0]          gain,
    input  logic signed [OFS_W-1:0] offset,
    input  logic                    sync_active,
    input  logic                    blank_active,
    input  logic [LUMA_W-1:0]       sync_level,
    input  logic [LUMA_W-1:0]       blank_level,
    output logic [LUMA_W-1:0]       luma_out
);
    luma_smp_t         smp;
    logic              hb_even;
    logic [LUMA_W-1:0] hb_center;

    luma_condition #(
        .Y_W(Y_W), .G_W(G_W), .G_FRAC(G_FRAC), .OFS_W(OFS_W)
    ) u_cond (
        .clk(clk), .rst(rst), .y_valid(y_valid), .y_in(y_in),
        .gain(gain), .offset(offset),
        .sync_active(sync_active), .blank_active(blank_active),
        .sync_level(sync_level), .blank_level(blank_level),
        .smp(smp)
    );

    luma_halfband u_hb (
        .clk(clk), .rst(rst), .smp(smp),
        .hb_even(hb_even), .hb_center(hb_center), .luma_out(luma_out)
    );

endmodule

// File: rtl/luma_interp_chk.sv
module luma_interp_chk
    import luma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              y_valid,
    input logic              sync_active,
    input logic              blank_active,
    input logic [LUMA_W-1:0] sync_level,
    input logic [LUMA_W-1:0] blank_level,
    input luma_smp_t         smp,
    input logic              hb_even,
    input logic [LUMA_W-1:0] hb_center,
    input logic [LUMA_W-1:0] luma_out
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> luma_out == '0); // R1

    AST_SYNC_WINS: assert property (@(posedge clk) disable iff (rst)
        (y_valid && sync_active) |=> smp.lvl == $past(sync_level)); // R4

    AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (y_valid && blank_active && !sync_active) |=> smp.lvl == $past(blank_level)); // R5

    AST_EVEN_PASS: assert property (@(posedge clk) disable iff (rst)
        hb_even |=> luma_out == $past(hb_center)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !y_valid |=> $stable(smp.lvl)); // R8

endmodule

bind luma_interp_path luma_interp_chk u_chk (.*);

// File: tb/tb_luma_interp_path.sv
module tb_luma_interp_path;
    import luma_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              y_valid = 1'b0;
    logic [7:0]        y_in = '0;
    logic [7:0]        gain = 8'd128;
    logic signed [9:0] offset = '0;
    logic              sync_active = 1'b0;
    logic              blank_active = 1'b0;
    logic [9:0]        sync_level = 10'd40;
    logic [9:0]        blank_level = 10'd240;
    logic [9:0]        luma_out;

    always #5 clk = ~clk;

    luma_interp_path dut (
        .clk(clk), .rst(rst), .y_valid(y_valid), .y_in(y_in), .gain(gain),
        .offset(offset), .sync_active(sync_active), .blank_active(blank_active),
        .sync_level(sync_level), .blank_level(blank_level), .luma_out(luma_out)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R1 reset";
    bit    done = 1'b0;

    // behavioural reference
    int m_x, m_out;
    bit m_xv, m_fresh;
    int t[$] = '{0, 0, 0, 0};

    function automatic int clampi(int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    always @(posedge clk) begin
        int nout;
        if (rst) begin
            m_x = 0; m_xv = 0; m_fresh = 0; m_out = 0;
            t = '{0, 0, 0, 0};
        end else begin
            if (m_fresh) nout = t[2];
            else nout = clampi((9 * (t[1] + t[2]) - t[0] - t[3] + 8) >>> 4);
            m_fresh = m_xv;
            if (m_xv) begin
                t.push_front(m_x);
                void'(t.pop_back());
            end
            m_xv = y_valid;
            if (y_valid) begin
                if (sync_active) m_x = int'(sync_level);
                else if (blank_active) m_x = int'(blank_level);
                else m_x = clampi(((int'(y_in) * int'(gain)) >>> 5) + int'(offset));
            end
            m_out = nout;
        end
    end

    task automatic check(input int exp_v, input string what);
        n_chk++;
        if (luma_out !== 10'(exp_v)) begin
            n_err++;
            $display("FAIL %s: luma_out=%0d expected=%0d", what, luma_out, exp_v);
        end
    endtask

    always @(negedge clk) if (!done) check(m_out, tag);

    task automatic send(input int y, input bit s, input bit b);
        @(negedge clk);
        y_valid = 1'b1; y_in = 8'(y); sync_active = s; blank_active = b;
        @(negedge clk);
        y_valid = 1'b0; y_in = 8'($urandom);
        sync_active = 1'($urandom); blank_active = 1'($urandom);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(0, "R1 idle after reset");

        tag = "R2 gain/offset unity";
        for (int i = 0; i < 20; i++) send(i * 13, 0, 0);
        for (int i = 0; i < 8; i++) send(100, 0, 0);
        check(400, "R2 unity gain steady 100->400");
        tag = "R2 gain/offset half gain negative offset";
        gain = 8'd64; offset = -10'sd40;
        for (int i = 0; i < 16; i++) send(255 - i * 15, 0, 0);
        tag = "R2 gain/offset high gain positive offset";
        gain = 8'd200; offset = 10'sd100;
        for (int i = 0; i < 16; i++) send((i * 37) % 200, 0, 0);

        tag = "R3 saturation high";
        gain = 8'd255; offset = 10'sd300;
        for (int i = 0; i < 8; i++) send(255, 0, 0);
        check(1023, "R3 clamp to 1023");
        tag = "R3 saturation low";
        gain = 8'd128; offset = -10'sd512;
        for (int i = 0; i < 8; i++) send(10, 0, 0);
        check(0, "R3 clamp to 0");
        tag = "R3 filter overshoot on steps";
        for (int i = 0; i < 12; i++) begin
            offset = (i % 3 == 0) ? 10'sd511 : -10'sd512;
            send(255, 0, 0);
        end

        tag = "R4 sync override";
        gain = 8'd128; offset = 10'sd0;
        for (int i = 0; i < 8; i++) send(200, 1, i[0]);
        check(40, "R4 sync tip level");

        tag = "R5 blank level";
        for (int i = 0; i < 8; i++) send(200, 0, 1);
        check(240, "R5 blanking level");
        tag = "R5 blank/sync edges";
        for (int i = 0; i < 12; i++) send(150, i % 4 == 1, i % 4 >= 2);

        tag = "R6/R7 impulse";
        for (int i = 0; i < 6; i++) send(0, 0, 0);
        send(100, 0, 0);
        for (int i = 0; i < 6; i++) send(0, 0, 0);

        tag = "R8 idle inputs ignored";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            y_in = 8'($urandom);
            sync_active = 1'($urandom);
            blank_active = 1'($urandom);
        end
        send(60, 0, 0);
        for (int i = 0; i < 10; i++) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule